// File: doc/BRIEF.md
# Absorption-Loop Setpoint Stepper and Integrator

This block closes the digital half of the running power-optimisation loop of a recording laser driver. It chooses a setpoint, either a plain register value or the output of a counter that an external controller advances one programmed step per strobe pulse. It subtracts a signed 8-bit absorption measurement from that setpoint and scales the difference by a power-of-two loop gain. The scaled error is accumulated into a laser correction that is kept inside programmable bounds.

A zero-forcing input lets the system freeze the loop. A mode bit decides whether the forcing clears the whole error or only the setpoint term. A stepping calibration sweep uses the strobe path. In normal writing the register setpoint is used and the correction follows the measurement samples.

Top module: `alp_loop_top`

## Requirements
- R1: While reset is held low, and after its release until other stimulus arrives, corr_o is 0, hit_hi_o and hit_lo_o are 0, and the internal step counter is 0.
- R2: When use_stepper_i is 0, setpoint_o equals reg_sp_i and the step counter loads start_i on every clock edge. When use_stepper_i is 1, setpoint_o equals the step counter.
- R3: Each rising edge of the asynchronous strobe_i adds step_i to the step counter exactly once while use_stepper_i is 1. The strobe passes a two-flop synchroniser and an edge detector, so the new value shows on setpoint_o after the third rising clock edge that samples strobe_i high. Holding strobe_i high adds no further steps.
- R4: The step counter saturates at the signed limits of its SP_W-bit width (511 and -512 by default) instead of wrapping.
- R5: loop_err_o = setpoint_o - meas_i, combinationally. meas_i is two's complement, -128 to +127.
- R6: With zero_force_i = 1 and zero_mode_i = 0, loop_err_o is 0.
- R7: With zero_force_i = 1 and zero_mode_i = 1, the setpoint term is replaced by 0, so loop_err_o = -meas_i.
- R8: On a sample, the value added to the accumulator is loop_err_o multiplied by 2^gain_shift_i, with gain_shift_i from 0 to 7.
- R9: corr_o updates only on the clock edge at which meas_valid_i is 1. Otherwise it holds.
- R10: On a sample, let the sum be corr_o plus the scaled error. If the sum exceeds lim_max_i, corr_o becomes lim_max_i and hit_hi_o becomes 1. Otherwise, if the sum is below lim_min_i, corr_o becomes lim_min_i and hit_lo_o becomes 1. Otherwise corr_o takes the sum and both flags become 0. The flags hold between samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Loop clock |
| rst_ni | input | 1 | Active-low reset |
| use_stepper_i | input | 1 | 1: setpoint from step counter; 0: from reg_sp_i |
| strobe_i | input | 1 | Asynchronous step strobe |
| step_i | input | SP_W (10) | Signed step size |
| start_i | input | SP_W (10) | Signed step counter preset |
| reg_sp_i | input | SP_W (10) | Signed register setpoint |
| zero_force_i | input | 1 | Zero-forcing request |
| zero_mode_i | input | 1 | 0: clear error; 1: clear setpoint term |
| meas_i | input | MEAS_W (8) | Signed absorption sample |
| meas_valid_i | input | 1 | Sample strobe for the accumulator |
| gain_shift_i | input | SH_W (3) | Loop gain as a left shift |
| lim_min_i | input | ACC_W (16) | Signed lower correction bound |
| lim_max_i | input | ACC_W (16) | Signed upper correction bound |
| setpoint_o | output | SP_W (10) | Selected setpoint |
| loop_err_o | output | SP_W+1 (11) | Signed loop error |
| corr_o | output | ACC_W (16) | Signed accumulated correction |
| hit_hi_o | output | 1 | Last sample clamped at upper bound |
| hit_lo_o | output | 1 | Last sample clamped at lower bound |

## Verification
setpoint_o and loop_err_o are combinational, so they are due in the same cycle as the inputs that set them. A step is due after the third rising edge that samples the strobe high. corr_o and both flags are due one edge after a sample. All inputs change on the falling edge, and all outputs are compared 1 ns after each rising edge against a behavioural model that advances on the same edge. The directed checks wait the exact number of edges listed above before they sample.

// File: rtl/alp_pkg.sv
package alp_pkg;
  typedef enum logic {
    ZM_CLEAR_ERR = 1'b0,
    ZM_CLEAR_SP  = 1'b1
  } zmode_e;
endpackage

// File: rtl/alp_strobe_edge.sv
module alp_strobe_edge #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic pulse_o
);
  // Synchroniser stages plus one history bit for the edge detector.
  logic [SYNC_N:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_N-1:0], strobe_i};
  end

  assign pulse_o = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
endmodule

// File: rtl/alp_step_gen.sv
module alp_step_gen #(
  parameter int SP_W = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   use_stepper_i,
  input  logic                   pulse_i,
  input  logic signed [SP_W-1:0] step_i,
  input  logic signed [SP_W-1:0] start_i,
  output logic signed [SP_W-1:0] step_q_o
);
  localparam int MSB = SP_W - 1;

  function automatic logic signed [SP_W-1:0] sat_add(
    input logic signed [SP_W-1:0] a,
    input logic signed [SP_W-1:0] b
  );
    logic signed [SP_W-1:0] s;
    s = a + b;
    if (!a[MSB] && !b[MSB] && s[MSB])      s = {1'b0, {(SP_W-1){1'b1}}};
    else if (a[MSB] && b[MSB] && !s[MSB])  s = {1'b1, {(SP_W-1){1'b0}}};
    return s;
  endfunction

  logic signed [SP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             step_q <= '0;
    else if (!use_stepper_i) step_q <= start_i;
    else if (pulse_i)        step_q <= sat_add(step_q, step_i);
  end

  assign step_q_o = step_q;
endmodule

// File: rtl/alp_err_acc.sv
module alp_err_acc
  import alp_pkg::*;
#(
  parameter int SP_W   = 10,
  parameter int MEAS_W = 8,
  parameter int ACC_W  = 16,
  parameter int SH_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SP_W-1:0]  sp_i,
  input  logic signed [MEAS_W-1:0] meas_i,
  input  logic                    meas_valid_i,
  input  logic                    zero_force_i,
  input  logic                    zero_mode_i,
  input  logic [SH_W-1:0]         gain_shift_i,
  input  logic signed [ACC_W-1:0] lim_min_i,
  input  logic signed [ACC_W-1:0] lim_max_i,
  output logic signed [SP_W:0]    err_o,
  output logic signed [ACC_W-1:0] corr_o,
  output logic                    hit_hi_o,
  output logic                    hit_lo_o
);
  localparam int ERR_W  = SP_W + 1;
  localparam int MAX_SH = (1 << SH_W) - 1;
  localparam int WIDE_A = ERR_W + MAX_SH;
  localparam int SUM_W  = ((WIDE_A > ACC_W) ? WIDE_A : ACC_W) + 2;

  function automatic logic signed [SUM_W-1:0] sx_err(input logic signed [ERR_W-1:0] v);
    return {{(SUM_W-ERR_W){v[ERR_W-1]}}, v};
  endfunction

  function automatic logic signed [SUM_W-1:0] sx_acc(input logic signed [ACC_W-1:0] v);
    return {{(SUM_W-ACC_W){v[ACC_W-1]}}, v};
  endfunction

  logic signed [ERR_W-1:0] sp_term, meas_term, err;
  logic signed [SUM_W-1:0] scaled, sum, lo_x, hi_x;
  logic signed [ACC_W-1:0] corr_q, corr_d;
  logic                    over, under, hit_hi_q, hit_lo_q;

  always_comb begin
    sp_term   = {{(ERR_W-SP_W){sp_i[SP_W-1]}}, sp_i};
    meas_term = {{(ERR_W-MEAS_W){meas_i[MEAS_W-1]}}, meas_i};
    if (zero_force_i && zmode_e'(zero_mode_i) == ZM_CLEAR_SP) sp_term = '0;
    err = sp_term - meas_term;
    if (zero_force_i && zmode_e'(zero_mode_i) == ZM_CLEAR_ERR) err = '0;
  end

  always_comb begin
    scaled = sx_err(err) <<< gain_shift_i;
    sum    = sx_acc(corr_q) + scaled;
    hi_x   = sx_acc(lim_max_i);
    lo_x   = sx_acc(lim_min_i);
    over   = sum > hi_x;
    under  = !over && (sum < lo_x);
    if (over)       corr_d = lim_max_i;
    else if (under) corr_d = lim_min_i;
    else            corr_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      corr_q   <= '0;
      hit_hi_q <= 1'b0;
      hit_lo_q <= 1'b0;
    end else if (meas_valid_i) begin
      corr_q   <= corr_d;
      hit_hi_q <= over;
      hit_lo_q <= under;
    end
  end

  assign err_o    = err;
  assign corr_o   = corr_q;
  assign hit_hi_o = hit_hi_q;
  assign hit_lo_o = hit_lo_q;
endmodule

// File: rtl/alp_loop_top.sv
module alp_loop_top #(
  parameter int SP_W   = 10,
  parameter int MEAS_W = 8,
  parameter int ACC_W  = 16,
  parameter int SH_W   = 3,
  parameter int SYNC_N = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     use_stepper_i,
  input  logic                     strobe_i,
  input  logic signed [SP_W-1:0]   step_i,
  input  logic signed [SP_W-1:0]   start_i,
  input  logic signed [SP_W-1:0]   reg_sp_i,
  input  logic                     zero_force_i,
  input  logic                     zero_mode_i,
  input  logic signed [MEAS_W-1:0] meas_i,
  input  logic                     meas_valid_i,
  input  logic [SH_W-1:0]          gain_shift_i,
  input  logic signed [ACC_W-1:0]  lim_min_i,
  input  logic signed [ACC_W-1:0]  lim_max_i,
  output logic signed [SP_W-1:0]   setpoint_o,
  output logic signed [SP_W:0]     loop_err_o,
  output logic signed [ACC_W-1:0]  corr_o,
  output logic                     hit_hi_o,
  output logic                     hit_lo_o
);
  // Named internal events, observed by the bound checker.
  logic                   step_pulse;
  logic signed [SP_W-1:0] step_q;

  alp_strobe_edge #(.SYNC_N(SYNC_N)) edge_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(strobe_i),
    .pulse_o (step_pulse)
  );

  alp_step_gen #(.SP_W(SP_W)) step_i_u (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .use_stepper_i(use_stepper_i),
    .pulse_i      (step_pulse),
    .step_i       (step_i),
    .start_i      (start_i),
    .step_q_o     (step_q)
  );

  assign setpoint_o = use_stepper_i ? step_q : reg_sp_i;

  alp_err_acc #(.SP_W(SP_W), .MEAS_W(MEAS_W), .ACC_W(ACC_W), .SH_W(SH_W)) acc_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sp_i        (setpoint_o),
    .meas_i      (meas_i),
    .meas_valid_i(meas_valid_i),
    .zero_force_i(zero_force_i),
    .zero_mode_i (zero_mode_i),
    .gain_shift_i(gain_shift_i),
    .lim_min_i   (lim_min_i),
    .lim_max_i   (lim_max_i),
    .err_o       (loop_err_o),
    .corr_o      (corr_o),
    .hit_hi_o    (hit_hi_o),
    .hit_lo_o    (hit_lo_o)
  );
endmodule

// File: rtl/alp_loop_chk.sv
module alp_loop_chk #(
  parameter int SP_W   = 10,
  parameter int MEAS_W = 8,
  parameter int ACC_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     use_stepper_i,
  input logic signed [SP_W-1:0]   start_i,
  input logic                     zero_force_i,
  input logic                     zero_mode_i,
  input logic signed [MEAS_W-1:0] meas_i,
  input logic                     meas_valid_i,
  input logic signed [ACC_W-1:0]  lim_min_i,
  input logic signed [ACC_W-1:0]  lim_max_i,
  input logic signed [SP_W:0]     loop_err_o,
  input logic signed [ACC_W-1:0]  corr_o,
  input logic                     hit_hi_o,
  input logic                     hit_lo_o,
  input logic                     step_pulse,
  input logic signed [SP_W-1:0]   step_q
);
  logic signed [SP_W:0] neg_meas;
  assign neg_meas = -{{(SP_W+1-MEAS_W){meas_i[MEAS_W-1]}}, meas_i};

  a_r2_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_stepper_i |=> step_q == $past(start_i));

  a_r3_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_pulse |=> !step_pulse);

  a_r3_step_only_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_stepper_i && !step_pulse) |=> $stable(step_q));

  a_r6_error_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_force_i && !zero_mode_i) |-> loop_err_o == '0);

  a_r7_setpoint_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_force_i && zero_mode_i) |-> loop_err_o == neg_meas);

  a_r9_hold_without_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_valid_i |=> $stable(corr_o) && $stable(hit_hi_o) && $stable(hit_lo_o));

  a_r10_within_bounds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid_i && lim_min_i <= lim_max_i) |=>
      (corr_o <= $past(lim_max_i) && corr_o >= $past(lim_min_i)));

  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_hi_o && hit_lo_o));
endmodule

bind alp_loop_top alp_loop_chk #(.SP_W(SP_W), .MEAS_W(MEAS_W), .ACC_W(ACC_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .use_stepper_i(use_stepper_i),
  .start_i      (start_i),
  .zero_force_i (zero_force_i),
  .zero_mode_i  (zero_mode_i),
  .meas_i       (meas_i),
  .meas_valid_i (meas_valid_i),
  .lim_min_i    (lim_min_i),
  .lim_max_i    (lim_max_i),
  .loop_err_o   (loop_err_o),
  .corr_o       (corr_o),
  .hit_hi_o     (hit_hi_o),
  .hit_lo_o     (hit_lo_o),
  .step_pulse   (step_pulse),
  .step_q       (step_q)
);

// File: tb/alp_loop_top_tb_top.sv
module alp_loop_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic use_stp = 1'b0, strobe = 1'b0, zf = 1'b0, zm = 1'b0, mval = 1'b0;
  logic signed [9:0]  step = '0, start = '0, reg_sp = '0;
  logic signed [7:0]  meas = '0;
  logic [2:0]         gsh = '0;
  logic signed [15:0] lmin = -16'sd30000, lmax = 16'sd30000;
  logic signed [9:0]  sp_o;
  logic signed [10:0] err_o;
  logic signed [15:0] corr_o;
  logic               hi_o, lo_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  alp_loop_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .use_stepper_i(use_stp), .strobe_i(strobe),
    .step_i(step), .start_i(start), .reg_sp_i(reg_sp), .zero_force_i(zf),
    .zero_mode_i(zm), .meas_i(meas), .meas_valid_i(mval), .gain_shift_i(gsh),
    .lim_min_i(lmin), .lim_max_i(lmax), .setpoint_o(sp_o), .loop_err_o(err_o),
    .corr_o(corr_o), .hit_hi_o(hi_o), .hit_lo_o(lo_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model.
  int m_step = 0, m_acc = 0, m_hi = 0, m_lo = 0;
  bit h1 = 0, h2 = 0, h3 = 0;

  function automatic int m_sp();
    return use_stp ? m_step : int'(reg_sp);
  endfunction

  function automatic int m_err();
    if (zf && !zm) return 0;
    if (zf && zm)  return -int'(meas);
    return m_sp() - int'(meas);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_step = 0; m_acc = 0; m_hi = 0; m_lo = 0; h1 = 0; h2 = 0; h3 = 0;
    end else begin
      if (mval) begin
        int s;
        s = m_acc + m_err() * (1 << gsh);
        if (s > int'(lmax))      begin m_acc = int'(lmax); m_hi = 1; m_lo = 0; end
        else if (s < int'(lmin)) begin m_acc = int'(lmin); m_hi = 0; m_lo = 1; end
        else                     begin m_acc = s;          m_hi = 0; m_lo = 0; end
      end
      if (!use_stp) m_step = int'(start);
      else if (h2 && !h3) begin
        m_step = m_step + int'(step);
        if (m_step > 511)  m_step = 511;
        if (m_step < -512) m_step = -512;
      end
      h3 = h2; h2 = h1; h1 = strobe;
    end
  end

  // Per-cycle comparison, 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk("R2/R3 setpoint_o", int'(sp_o), m_sp());
      chk("R5 loop_err_o", int'(err_o), m_err());
      chk("R9 corr_o", int'(corr_o), m_acc);
      chk("R10 hit_hi_o", int'(hi_o), m_hi);
      chk("R10 hit_lo_o", int'(lo_o), m_lo);
    end
  end

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic sample_once();
    @(negedge clk); mval = 1'b1;
    @(negedge clk); mval = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset corr", int'(corr_o), 0);
    chk("R1 reset flags", int'(hi_o) + int'(lo_o), 0);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    chk("R1 after release corr", int'(corr_o), 0);
    // R2 direct setpoint and R5 error.
    @(negedge clk); reg_sp = 10'sd100; meas = 8'sd30;
    edges(1);
    chk("R2 reg setpoint", int'(sp_o), 100);
    chk("R5 error 100-30", int'(err_o), 70);
    @(negedge clk); meas = -8'sd128;
    edges(1);
    chk("R5 error with -128", int'(err_o), 228);
    // R3 stepping from a preset.
    @(negedge clk); start = 10'sd20; step = 10'sd5;
    edges(1);
    @(negedge clk); use_stp = 1'b1;
    edges(1);
    chk("R2 stepper preset", int'(sp_o), 20);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); strobe = 1'b1;
      edges(2);
      chk("R3 not yet stepped", int'(sp_o), 20 + 5 * k);
      edges(1);
      chk("R3 step after third edge", int'(sp_o), 25 + 5 * k);
      edges(5);
      chk("R3 held strobe single step", int'(sp_o), 25 + 5 * k);
      @(negedge clk); strobe = 1'b0;
      edges(3);
    end
    // R4 saturation both ways.
    @(negedge clk); use_stp = 1'b0; start = 10'sd500; step = 10'sd50;
    @(negedge clk); use_stp = 1'b1; strobe = 1'b1;
    edges(4);
    chk("R4 positive saturation", int'(sp_o), 511);
    @(negedge clk); strobe = 1'b0; use_stp = 1'b0; start = -10'sd500; step = -10'sd50;
    @(negedge clk); use_stp = 1'b1; strobe = 1'b1;
    edges(4);
    chk("R4 negative saturation", int'(sp_o), -512);
    @(negedge clk); strobe = 1'b0; use_stp = 1'b0;
    // R6 / R7 zero forcing.
    @(negedge clk); reg_sp = 10'sd60; meas = -8'sd40; zf = 1'b1; zm = 1'b0;
    edges(1);
    chk("R6 error cleared", int'(err_o), 0);
    sample_once();
    edges(1);
    chk("R6 accumulator unchanged", int'(corr_o), 0);
    @(negedge clk); zm = 1'b1;
    edges(1);
    chk("R7 setpoint cleared", int'(err_o), 40);
    @(negedge clk); zf = 1'b0; zm = 1'b0;
    // R8 gain and R9 hold.
    @(negedge clk); reg_sp = 10'sd10; meas = 8'sd0; gsh = 3'd3; mval = 1'b1;
    edges(1);
    chk("R8 scaled by 8", int'(corr_o), 80);
    @(negedge clk); mval = 1'b0; reg_sp = 10'sd300;
    edges(4);
    chk("R9 hold without sample", int'(corr_o), 80);
    // R10 upper and lower clamp.
    @(negedge clk); lmax = 16'sd100; lmin = -16'sd50; reg_sp = 10'sd10; mval = 1'b1;
    edges(1);
    chk("R10 clamp to max", int'(corr_o), 100);
    chk("R10 hi flag", int'(hi_o), 1);
    @(negedge clk); reg_sp = -10'sd200; gsh = 3'd0;
    edges(1);
    chk("R10 clamp to min", int'(corr_o), -50);
    chk("R10 lo flag", int'(lo_o), 1);
    @(negedge clk); reg_sp = 10'sd20;
    edges(1);
    chk("R10 flags clear", int'(hi_o) + int'(lo_o), 0);
    chk("R10 unclamped sum", int'(corr_o), -30);
    @(negedge clk); mval = 1'b0; lmin = -16'sd30000; lmax = 16'sd30000;
    // Varied patterns against the model.
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      use_stp = ($urandom % 4) != 0;
      strobe  = ($urandom % 3) == 0;
      step    = 10'($signed($urandom % 61) - 30);
      start   = 10'($signed($urandom % 1024) - 512);
      reg_sp  = 10'($urandom);
      meas    = 8'($urandom);
      zf      = ($urandom % 6) == 0;
      zm      = 1'($urandom);
      mval    = 1'($urandom);
      gsh     = 3'($urandom);
      lmax    = 16'sd4000 + 16'($urandom % 2000);
      lmin    = -16'sd4000 - 16'($urandom % 2000);
    end
    @(negedge clk); mval = 1'b0;
    edges(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule